// File: doc/BRIEF.md
# Sample Packetizer with Automatic Packet Commit

The block captures a parallel sample bus, one byte per sample strobe, and collects the bytes into packets of a programmable length. As soon as a packet holds the programmed number of bytes, it is handed to the output side without any further request. Writing then moves on to the next buffer of a small ring of packet buffers. The output side drains the committed packets in the order they were filled. It presents them as a byte stream with valid/ready handshaking and a last marker on the final byte of every packet.

When every buffer in the ring holds a committed packet that has not yet been drained, the block raises a full flag. Upstream sampling logic treats this flag as a stop signal: it is a flow-control decision, not an error. Strobes that still arrive while the flag is up are dropped and counted.

Three pulse inputs control the block:
- `start` arms capture and latches the packet length.
- `abort` disarms capture.
- `fifo_clr` discards everything buffered and returns all pointers to their initial position.

Output stream rules:
- A byte is transferred on a clock edge where `m_valid` and `m_ready` are both high.
- While `m_ready` is low, the offered byte, its last marker and `m_valid` hold unchanged.
- There is no back-pressure on the sample side. Its only throttle is `full`.

Top module: `sample_packer`

## Requirements
- R1: While `rst_n` is low and after its release, `m_valid`, `full` and `capturing` read 0 and `ovf_count` reads 0.
- R2: On `start`, the packet length {len_hi,len_lo} (len_hi in bits 15:8) is latched. A value of 0, or a value above BUF_DEPTH, is replaced by BUF_DEPTH. Each accepted strobe stores `smp_data` as one byte. After exactly that many accepted bytes, the packet is committed.
- R3: Bytes leave in the order they were sampled, and packets leave in commit order. `m_last` is 1 exactly on the final byte of each packet.
- R4: `full` is 1 from the clock edge that commits the NUM_BUF-th undrained packet. It falls at the edge where the last byte of a packet is accepted, and not earlier.
- R5: A strobe that arrives while capturing and `full` is 1 is not stored, and `ovf_count` increases by one. `start` clears `ovf_count`.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` stay unchanged on the next cycle.
- R7: `fifo_clr` discards all committed packets and the partially filled packet. After the edge it is sampled, `m_valid` and `full` are 0. `capturing` and `ovf_count` are not changed.
- R8: `start` sets `capturing` and `abort` clears it, both at the next edge, and `abort` wins if both are high. While not capturing, strobes are neither stored nor counted. A new `start` discards any partial packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clr | input | 1 | Pulse: empty all buffers and reset pointers |
| start | input | 1 | Pulse: arm capture, latch length, clear overflow count |
| abort | input | 1 | Pulse: disarm capture |
| len_hi | input | 8 | Packet length, upper byte |
| len_lo | input | 8 | Packet length, lower byte |
| smp_strobe | input | 1 | One sample present on this cycle |
| smp_data | input | DATA_W | Sample bus |
| full | output | 1 | No free buffer; stop sampling |
| capturing | output | 1 | Capture armed |
| ovf_count | output | OVF_W | Strobes dropped while full |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte accepted |
| m_data | output | DATA_W | Output byte |
| m_last | output | 1 | Final byte of a packet |

## Verification
The bench builds the block with BUF_DEPTH = 8 and NUM_BUF = 4, keeping OVF_W at 8. With these values the clamp of out-of-range lengths is reached with 8-byte packets, and all four buffers fill after a few dozen strobes. Overflow, the exact edge where `full` falls and the ring wrap-around are therefore exercised many times in a short run. With the default 512-byte packets these cases would need thousands of cycles each.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic { CAP_IDLE = 1'b0, CAP_RUN = 1'b1 } cap_state_e;

  // Zero or over-size lengths fall back to the full buffer depth.
  function automatic logic [31:0] clamp_len(input logic [31:0] raw,
                                            input logic [31:0] depth);
    return (raw == 32'd0 || raw > depth) ? depth : raw;
  endfunction

endpackage

// File: rtl/sp_capture_ctrl.sv
module sp_capture_ctrl #(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  parameter int LEN_W     = 16,
  parameter int OVF_W     = 16,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic              start,
  input  logic              abort,
  input  logic [LEN_W-1:0]  len_raw,
  input  logic              strobe,
  input  logic              full,
  output logic              capturing,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_buf,
  output logic [ADDR_W-1:0] wr_ofs,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_len,
  output logic [OVF_W-1:0]  ovf_count
);
  import sp_pkg::*;

  cap_state_e        state_q;
  logic [CNT_W-1:0]  len_q;
  logic [ADDR_W-1:0] ofs_q;
  logic [IDX_W-1:0]  buf_q;
  logic [OVF_W-1:0]  ovf_q;
  logic              quiet;

  assign quiet     = !fifo_clr && !start && !abort;
  assign capturing = (state_q == CAP_RUN);
  assign wr_en     = capturing && strobe && !full && quiet;
  assign commit    = wr_en && (ADDR_W'(len_q - CNT_W'(1)) == ofs_q);
  assign wr_buf    = buf_q;
  assign wr_ofs    = ofs_q;
  assign commit_len = len_q;
  assign ovf_count = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      len_q   <= CNT_W'(BUF_DEPTH);
    end else if (abort) begin
      state_q <= CAP_IDLE;
    end else if (start) begin
      state_q <= CAP_RUN;
      len_q   <= CNT_W'(clamp_len(32'(len_raw), 32'(BUF_DEPTH)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      ofs_q <= '0;
      buf_q <= '0;
    end else if (start) begin
      ofs_q <= '0;
    end else if (commit) begin
      ofs_q <= '0;
      buf_q <= (buf_q == IDX_W'(NUM_BUF - 1)) ? '0 : buf_q + 1'b1;
    end else if (wr_en) begin
      ofs_q <= ofs_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else if (start && !abort) begin
      ovf_q <= '0;
    end else if (capturing && strobe && full && quiet) begin
      ovf_q <= ovf_q + 1'b1;
    end
  end

endmodule

// File: rtl/sp_buf_store.sv
module sp_buf_store #(
  parameter int DATA_W    = 8,
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int TOTAL    = NUM_BUF * BUF_DEPTH,
  localparam int TA_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_buf,
  input  logic [ADDR_W-1:0] wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic [CNT_W-1:0]  commit_len,
  input  logic [IDX_W-1:0]  rd_buf,
  input  logic [ADDR_W-1:0] rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_len
);

  logic [DATA_W-1:0] mem [TOTAL];
  logic [CNT_W-1:0]  len_tbl [NUM_BUF];
  logic [TA_W-1:0]   wr_addr;
  logic [TA_W-1:0]   rd_addr;

  assign wr_addr = TA_W'(wr_buf) * TA_W'(BUF_DEPTH) + TA_W'(wr_ofs);
  assign rd_addr = TA_W'(rd_buf) * TA_W'(BUF_DEPTH) + TA_W'(rd_ofs);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // One length register per buffer, written when that buffer commits.
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_len
    always_ff @(posedge clk) begin
      if (!rst_n) len_tbl[b] <= CNT_W'(BUF_DEPTH);
      else if (commit && wr_buf == IDX_W'(b)) len_tbl[b] <= commit_len;
    end
  end

  assign rd_data = mem[rd_addr];
  assign rd_len  = len_tbl[rd_buf];

endmodule

// File: rtl/sp_drain_ctrl.sv
module sp_drain_ctrl #(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic              have_pkt,
  input  logic [CNT_W-1:0]  rd_len,
  input  logic              m_ready,
  output logic [IDX_W-1:0]  rd_buf,
  output logic [ADDR_W-1:0] rd_ofs,
  output logic              m_valid,
  output logic              m_last,
  output logic              release_buf
);

  logic [IDX_W-1:0]  buf_q;
  logic [ADDR_W-1:0] ofs_q;
  logic              xfer;

  assign m_valid     = have_pkt;
  assign m_last      = have_pkt && (CNT_W'(ofs_q) == rd_len - CNT_W'(1));
  assign xfer        = m_valid && m_ready && !fifo_clr;
  assign release_buf = xfer && m_last;
  assign rd_buf      = buf_q;
  assign rd_ofs      = ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      buf_q <= '0;
      ofs_q <= '0;
    end else if (release_buf) begin
      ofs_q <= '0;
      buf_q <= (buf_q == IDX_W'(NUM_BUF - 1)) ? '0 : buf_q + 1'b1;
    end else if (xfer) begin
      ofs_q <= ofs_q + 1'b1;
    end
  end

endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int DATA_W    = 8,
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 512,
  parameter int OVF_W     = 16,
  localparam int LEN_W    = 16,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int ADDR_W   = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int OCC_W    = $clog2(NUM_BUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic              start,
  input  logic              abort,
  input  logic [7:0]        len_hi,
  input  logic [7:0]        len_lo,
  input  logic              smp_strobe,
  input  logic [DATA_W-1:0] smp_data,
  output logic              full,
  output logic              capturing,
  output logic [OVF_W-1:0]  ovf_count,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last
);

  logic              wr_en, commit, release_buf;
  logic [IDX_W-1:0]  wr_buf, rd_buf;
  logic [ADDR_W-1:0] wr_ofs, rd_ofs;
  logic [CNT_W-1:0]  commit_len, rd_len;
  logic [OCC_W-1:0]  occ_q;

  sp_capture_ctrl #(
    .NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .OVF_W(OVF_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .start(start),
    .abort(abort), .len_raw({len_hi, len_lo}), .strobe(smp_strobe),
    .full(full), .capturing(capturing), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_ofs(wr_ofs), .commit(commit), .commit_len(commit_len),
    .ovf_count(ovf_count)
  );

  sp_buf_store #(
    .DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_ofs(wr_ofs), .wr_data(smp_data), .commit(commit),
    .commit_len(commit_len), .rd_buf(rd_buf), .rd_ofs(rd_ofs),
    .rd_data(m_data), .rd_len(rd_len)
  );

  sp_drain_ctrl #(
    .NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .have_pkt(occ_q != '0),
    .rd_len(rd_len), .m_ready(m_ready), .rd_buf(rd_buf), .rd_ofs(rd_ofs),
    .m_valid(m_valid), .m_last(m_last), .release_buf(release_buf)
  );

  // Number of committed, not yet drained buffers.
  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) occ_q <= '0;
    else case ({commit, release_buf})
      2'b10:   occ_q <= occ_q + 1'b1;
      2'b01:   occ_q <= occ_q - 1'b1;
      default: occ_q <= occ_q;
    endcase
  end

  assign full = (occ_q == OCC_W'(NUM_BUF));

endmodule

// File: rtl/sp_packer_chk.sv
module sp_packer_chk #(
  parameter int DATA_W = 8,
  parameter int OVF_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_clr,
  input logic              start,
  input logic              abort,
  input logic              smp_strobe,
  input logic              full,
  input logic              capturing,
  input logic [OVF_W-1:0]  ovf_count,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last
);

  a_r4_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> m_valid);

  a_r5_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && full && smp_strobe && !start && !abort && !fifo_clr)
    |=> ovf_count == OVF_W'($past(ovf_count) + 1'b1));

  a_r5_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_strobe && !start) |=> $stable(ovf_count));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !fifo_clr)
    |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!m_valid && !full));

  a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !capturing);

  a_r8_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> capturing);

endmodule

bind sample_packer sp_packer_chk #(.DATA_W(DATA_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .start(start),
  .abort(abort), .smp_strobe(smp_strobe), .full(full),
  .capturing(capturing), .ovf_count(ovf_count), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
);

// File: tb/sample_packer_tb.sv
module sample_packer_tb;
  localparam int DW = 8, NB = 4, BD = 8, OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 0, start = 0, abort = 0, smp_strobe = 0, m_ready = 0;
  logic [7:0] len_hi = 0, len_lo = 0;
  logic [DW-1:0] smp_data = 0;
  logic full, capturing, m_valid, m_last;
  logic [OW-1:0] ovf_count;
  logic [DW-1:0] m_data;

  int nvec = 0, nerr = 0;

  always #5 clk = ~clk;

  sample_packer #(.DATA_W(DW), .NUM_BUF(NB), .BUF_DEPTH(BD), .OVF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .start(start),
    .abort(abort), .len_hi(len_hi), .len_lo(len_lo),
    .smp_strobe(smp_strobe), .smp_data(smp_data), .full(full),
    .capturing(capturing), .ovf_count(ovf_count), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  // {raw length, first data byte}
  localparam logic [23:0] VEC [6] = '{
    {16'h0003, 8'h10}, {16'h0008, 8'h20}, {16'h0000, 8'h30},
    {16'h0105, 8'h40}, {16'h0001, 8'h50}, {16'h0005, 8'h60}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    smp_strobe = 1; smp_data = d;
    @(negedge clk);
    smp_strobe = 0;
  endtask

  task automatic do_start(input logic [15:0] len);
    len_hi = len[15:8]; len_lo = len[7:0]; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_clr();
    fifo_clr = 1;
    @(negedge clk);
    fifo_clr = 0;
  endtask

  task automatic drain_byte(input string tag, input logic [7:0] d, input logic last);
    check({tag, " valid"}, 32'(m_valid), 32'd1);
    check({tag, " data"}, 32'(m_data), 32'(d));
    check({tag, " last"}, 32'(m_last), 32'(last));
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
  endtask

  function automatic int eff(input logic [15:0] raw);
    return (raw == 0 || raw > BD) ? BD : int'(raw);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(m_valid), 0);
    check("R1 full", 32'(full), 0);
    check("R1 capturing", 32'(capturing), 0);
    check("R1 ovf", 32'(ovf_count), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after release", 32'(m_valid), 0);

    // Table: R2 length clamp, R3 order and last marker
    for (int v = 0; v < 6; v++) begin
      automatic logic [15:0] len = VEC[v][23:8];
      automatic logic [7:0]  base = VEC[v][7:0];
      automatic int          n = eff(len);
      pulse_clr();
      do_start(len);
      check("R8 capturing after start", 32'(capturing), 1);
      for (int i = 0; i < 2 * n; i++) push(8'(base + i));
      check("R4 two packets not full", 32'(full), 0);
      for (int i = 0; i < 2 * n; i++)
        drain_byte("R2 R3 table", 8'(base + i), (i % n) == n - 1);
      check("R2 exact packet count", 32'(m_valid), 0);
    end

    // R4 / R5: fill all buffers, overflow, release edge
    pulse_clr();
    do_start(16'd2);
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    check("R4 full after four packets", 32'(full), 1);
    push(8'hEE);
    push(8'hEE);
    check("R5 overflow count", 32'(ovf_count), 2);
    drain_byte("R4 first byte", 8'hA0, 1'b0);
    check("R4 still full mid packet", 32'(full), 1);
    drain_byte("R4 last byte", 8'hA1, 1'b1);
    check("R4 freed after last", 32'(full), 0);
    push(8'hB0);
    push(8'hB1);
    check("R4 full again", 32'(full), 1);
    for (int i = 2; i < 8; i++) drain_byte("R5 dropped not stored", 8'hA0 + 8'(i), i[0]);
    drain_byte("R3 wrap order", 8'hB0, 1'b0);
    drain_byte("R3 wrap order", 8'hB1, 1'b1);
    check("R3 empty", 32'(m_valid), 0);

    // R6: back-pressure
    do_start(16'd3);
    check("R5 start clears ovf", 32'(ovf_count), 0);
    push(8'h71); push(8'h72); push(8'h73);
    repeat (3) @(negedge clk);
    check("R6 valid held", 32'(m_valid), 1);
    check("R6 data held", 32'(m_data), 32'h71);
    check("R6 last held", 32'(m_last), 0);

    // R7: clear discards committed and partial packets
    push(8'h74);
    pulse_clr();
    check("R7 valid cleared", 32'(m_valid), 0);
    check("R7 full cleared", 32'(full), 0);
    check("R7 capture kept", 32'(capturing), 1);
    push(8'hC0); push(8'hC1); push(8'hC2);
    drain_byte("R7 fresh", 8'hC0, 1'b0);
    drain_byte("R7 fresh", 8'hC1, 1'b0);
    drain_byte("R7 fresh", 8'hC2, 1'b1);

    // R8: abort ignores strobes, start drops partial packet
    push(8'hD0);
    abort = 1;
    @(negedge clk);
    abort = 0;
    check("R8 abort stops", 32'(capturing), 0);
    for (int i = 0; i < 5; i++) push(8'hD1);
    check("R8 nothing stored", 32'(m_valid), 0);
    check("R8 nothing counted", 32'(ovf_count), 0);
    do_start(16'd3);
    push(8'hE0); push(8'hE1); push(8'hE2);
    drain_byte("R8 restart", 8'hE0, 1'b0);
    drain_byte("R8 restart", 8'hE1, 1'b0);
    drain_byte("R8 restart", 8'hE2, 1'b1);
    check("R8 empty", 32'(m_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule